// File: doc/BRIEF.md
# Multi-Channel DAC Update Controller

This block sits between a host register port and a group of serial-input converters: several output channels plus a positive and a negative reference converter. Each converter has a setting register. When the host writes a setting, the block latches the value, raises that converter's busy flag and queues a 16-bit serial update. All converters share one serial clock and one data line, and each has its own select line. Updates run one at a time. The host polls a single status word until the busy flag it cares about drops.

A control register at the same address as the status word takes short command codes. A code can enable or disable a channel, choose signed or unsigned channel data, switch a pattern-mode flag, or discard writes that are waiting behind a running update. A write that reaches a converter that is still busy is kept in a one-deep hold slot and goes out as soon as the current update for that converter has finished.

Top module: `dac_update_ctrl`

## Requirements
- R1: A write to byte address 0x38 + 2n (n < NUM_CH) stores the value as channel n's setting, readable at the same address, and requests an update of converter n. A write to any unmapped address changes no readback, no status bit and starts no update.
- R2: The converter's busy flag reads 1 in the status word (address 0x20) on the cycle after its write. Channel n's flag is status bit 4+n. Bit 1 is the OR of the two reference converters' flags.
- R3: An update asserts exactly one select line for the whole word. It shifts 16 bits MSB first. Each bit lasts 2*SCLK_DIV cycles, and the data line is stable while the serial clock rises.
- R4: A converter's busy flag falls one cycle after its select drops at the end of the last bit. A select line is never high while that converter is not busy.
- R5: A write to a converter that is still busy is held and shifted after the current update. Status bit 0 reads 1 while any hold slot is full. A later write replaces the held value.
- R6: When several converters wait, the lowest index goes first: channels in ascending order, then the positive reference (index NUM_CH), then the negative reference (index NUM_CH+1).
- R7: A write to address 0x2C goes to the positive reference converter when bit 8 is 1 and to the negative one when bit 8 is 0. The 16-bit word is shifted unchanged. The register reads back the last value written and resets to 0x0080.
- R8: A control write whose bits [7:4] equal n+2 sets channel n's enable to bit 0. The enable is reported in status bit 8+n.
- R9: A control write with bits [7:4] = 0 and bit 2 = 0 sets signed mode to bit 1 (status bit 13). In signed mode, bit 15 of a channel word is inverted when its shift starts. Reference words are never altered.
- R10: Control code 0x0004 discards every held write and clears status bit 0. Updates that have already been requested still complete.
- R11: Control codes 0x0061 and 0x0060 set and clear the pattern-mode flag, reported in status bit 12.
- R12: After reset the status word, including the unused bits 2 and 3, reads 0. Every channel setting reads 0, no select is high and the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 8 | Byte address for read and write |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for host_addr (combinational) |
| ser_clk | output | 1 | Shared serial clock |
| ser_data | output | 1 | Shared serial data, MSB first |
| ser_sel | output | NUM_CH+2 | Per-converter select, active high |

## Verification
The assertions assume the host drives at most one write per cycle and that the address and data are valid whenever the write strobe is high. The busy-follows-write property also assumes that a write to a converter is only ever followed by that converter's own update, so nothing outside the block may clear a flag. The bench produces one write per cycle from tasks, and its random phase draws converters and data from $urandom while waiting for the block to go idle between transfers. Directed sequences push the hold slots, the discard command and the arbitration order into back-to-back writes.

// File: rtl/dacu_pkg.sv
// Shared constants and types for the DAC update controller.
package dacu_pkg;
    localparam int unsigned WORD_W       = 16;
    localparam logic [7:0]  ADDR_CTRL    = 8'h20;
    localparam logic [7:0]  ADDR_REF     = 8'h2C;
    localparam logic [7:0]  ADDR_CH_BASE = 8'h38;
    localparam logic [15:0] CODE_FLUSH   = 16'h0004;
    localparam logic [3:0]  GRP_MODE     = 4'h0;
    localparam logic [3:0]  GRP_CH_BASE  = 4'h2;
    localparam logic [3:0]  GRP_PATTERN  = 4'h6;
    localparam logic [15:0] REF_RESET    = 16'h0080;

    typedef enum logic {SH_IDLE, SH_RUN} shift_state_e;
endpackage

// File: rtl/dacu_regs.sv
// Register decode, setting shadows, mode flags and read mux.
// Assumes at most one write per cycle; reads are combinational on host_addr.
module dacu_regs
    import dacu_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    localparam int unsigned NCONV = NUM_CH + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [7:0]        addr,
    input  logic [15:0]       wdata,
    input  logic [NCONV-1:0]  busy,
    input  logic [NCONV-1:0]  pend,
    output logic [15:0]       rdata,
    output logic [NCONV-1:0]  conv_wr,
    output logic              flush,
    output logic              signed_mode
);
    logic [NUM_CH-1:0] ch_hit;
    logic              ref_hit;
    logic              ctrl_hit;
    logic [3:0]        grp;
    logic [15:0]       shadow [NUM_CH];
    logic [15:0]       ref_shadow;
    logic [NUM_CH-1:0] ena;
    logic              pattern;
    logic [15:0]       status;

    // Address decode for each channel setting register
    for (genvar n = 0; n < NUM_CH; n++) begin : g_hit
        assign ch_hit[n] = wr && (addr == ADDR_CH_BASE + 8'(2 * n));
    end

    assign ref_hit  = wr && (addr == ADDR_REF);
    assign ctrl_hit = wr && (addr == ADDR_CTRL);
    assign grp      = wdata[7:4];
    assign conv_wr  = {ref_hit & ~wdata[8], ref_hit & wdata[8], ch_hit};
    assign flush    = ctrl_hit && (wdata == CODE_FLUSH);

    // Setting and reference shadows for readback
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < NUM_CH; n++) shadow[n] <= '0;
            ref_shadow <= REF_RESET;
        end else begin
            for (int n = 0; n < NUM_CH; n++)
                if (ch_hit[n]) shadow[n] <= wdata;
            if (ref_hit) ref_shadow <= wdata;
        end
    end

    // Control command decode into enable and mode flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena         <= '0;
            pattern     <= 1'b0;
            signed_mode <= 1'b0;
        end else if (ctrl_hit) begin
            if (grp == GRP_MODE && !wdata[2]) signed_mode <= wdata[1];
            if (grp == GRP_PATTERN) pattern <= wdata[0];
            for (int n = 0; n < NUM_CH; n++)
                if (grp == GRP_CH_BASE + 4'(n)) ena[n] <= wdata[0];
        end
    end

    // Status word assembly
    always_comb begin
        status              = '0;
        status[0]           = |pend;
        status[1]           = busy[NUM_CH] | busy[NUM_CH+1];
        status[4 +: NUM_CH] = busy[NUM_CH-1:0];
        status[8 +: NUM_CH] = ena;
        status[12]          = pattern;
        status[13]          = signed_mode;
    end

    // Read mux
    always_comb begin
        rdata = '0;
        if (addr == ADDR_CTRL) rdata = status;
        if (addr == ADDR_REF)  rdata = ref_shadow;
        for (int n = 0; n < NUM_CH; n++)
            if (addr == ADDR_CH_BASE + 8'(2 * n)) rdata = shadow[n];
    end
endmodule

// File: rtl/dacu_slot.sv
// Per-converter update slot: busy flag, word to shift and one-deep hold.
// Assumes done pulses only while busy; flush and wr never share a cycle.
module dacu_slot
    import dacu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              flush,
    input  logic              done,
    output logic              busy,
    output logic              pend,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] hold_d;

    // Accept writes, queue behind a running update, retire on done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            pend   <= 1'b0;
            word   <= '0;
            hold_d <= '0;
        end else begin
            if (done) begin
                if (pend) begin
                    word <= hold_d;
                    pend <= 1'b0;
                end else begin
                    busy <= 1'b0;
                end
            end
            if (flush) pend <= 1'b0;
            if (wr) begin
                if (!busy || (done && !pend)) begin
                    word <= wdata;
                    busy <= 1'b1;
                end else begin
                    hold_d <= wdata;
                    pend   <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dacu_shifter.sv
// Shared serial engine: picks the lowest busy converter, shifts 16 bits
// MSB first at 2*SCLK_DIV cycles per bit, then pulses done for one cycle.
module dacu_shifter
    import dacu_pkg::*;
#(
    parameter int unsigned NCONV    = 6,
    parameter int unsigned NUM_CH   = 4,
    parameter int unsigned SCLK_DIV = 2,
    localparam int unsigned IDX_W   = $clog2(NCONV),
    localparam int unsigned CNT_W   = $clog2(2 * SCLK_DIV),
    localparam int unsigned BIT_W   = $clog2(WORD_W)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCONV-1:0]        busy,
    input  logic [NCONV*WORD_W-1:0] words,
    input  logic                    signed_mode,
    output logic [NCONV-1:0]        done,
    output logic                    sclk,
    output logic                    sdo,
    output logic [NCONV-1:0]        sel
);
    localparam logic [CNT_W-1:0] DIV_LAST = CNT_W'(2 * SCLK_DIV - 1);
    localparam logic [CNT_W-1:0] DIV_HALF = CNT_W'(SCLK_DIV);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

    shift_state_e      state;
    logic [IDX_W-1:0]  grant;
    logic [IDX_W-1:0]  pick;
    logic [NCONV-1:0]  cand;
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] load;
    logic [BIT_W-1:0]  bitcnt;
    logic [CNT_W-1:0]  divcnt;

    assign cand = busy & ~done;

    // Lowest-index arbitration among waiting converters
    always_comb begin
        pick = '0;
        for (int i = NCONV - 1; i >= 0; i--)
            if (cand[i]) pick = IDX_W'(i);
    end

    // Word to load, with sign conversion for output channels
    always_comb begin
        load = words[pick * WORD_W +: WORD_W];
        if (signed_mode && (int'(pick) < NUM_CH)) load[WORD_W-1] = ~load[WORD_W-1];
    end

    // Shift sequencing and bit timing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SH_IDLE;
            grant  <= '0;
            shreg  <= '0;
            bitcnt <= '0;
            divcnt <= '0;
            done   <= '0;
        end else begin
            done <= '0;
            if (state == SH_IDLE) begin
                if (|cand) begin
                    state  <= SH_RUN;
                    grant  <= pick;
                    shreg  <= load;
                    bitcnt <= '0;
                    divcnt <= '0;
                end
            end else if (divcnt == DIV_LAST) begin
                divcnt <= '0;
                if (bitcnt == BIT_LAST) begin
                    state       <= SH_IDLE;
                    done[grant] <= 1'b1;
                end else begin
                    shreg  <= shreg << 1;
                    bitcnt <= bitcnt + 1'b1;
                end
            end else begin
                divcnt <= divcnt + 1'b1;
            end
        end
    end

    assign sclk = (state == SH_RUN) && (divcnt >= DIV_HALF);
    assign sdo  = (state == SH_RUN) && shreg[WORD_W-1];
    assign sel  = (state == SH_RUN) ? (NCONV'(1) << grant) : '0;
endmodule

// File: rtl/dac_update_ctrl.sv
// Top level: register port, one update slot per converter, shared shifter.
// Converter index: 0..NUM_CH-1 channels, NUM_CH positive ref, NUM_CH+1 negative ref.
// Assumes NUM_CH is 1 to 4 (the status word has four channel busy bits).
module dac_update_ctrl
    import dacu_pkg::*;
#(
    parameter int unsigned NUM_CH   = 4,
    parameter int unsigned SCLK_DIV = 2,
    localparam int unsigned NCONV   = NUM_CH + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic [7:0]       host_addr,
    input  logic [15:0]      host_wdata,
    output logic [15:0]      host_rdata,
    output logic             ser_clk,
    output logic             ser_data,
    output logic [NCONV-1:0] ser_sel
);
    logic [NCONV-1:0]        conv_wr;
    logic [NCONV-1:0]        conv_busy;
    logic [NCONV-1:0]        conv_pend;
    logic [NCONV-1:0]        conv_done;
    logic [NCONV*WORD_W-1:0] conv_words;
    logic                    flush;
    logic                    signed_mode;

    dacu_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(host_wr), .addr(host_addr),
        .wdata(host_wdata), .busy(conv_busy), .pend(conv_pend),
        .rdata(host_rdata), .conv_wr(conv_wr), .flush(flush),
        .signed_mode(signed_mode)
    );

    // One update slot per converter
    for (genvar i = 0; i < NCONV; i++) begin : g_slot
        dacu_slot u_slot (
            .clk(clk), .rst_n(rst_n), .wr(conv_wr[i]), .wdata(host_wdata),
            .flush(flush), .done(conv_done[i]), .busy(conv_busy[i]),
            .pend(conv_pend[i]), .word(conv_words[i*WORD_W +: WORD_W])
        );
    end

    dacu_shifter #(.NCONV(NCONV), .NUM_CH(NUM_CH), .SCLK_DIV(SCLK_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .busy(conv_busy), .words(conv_words),
        .signed_mode(signed_mode), .done(conv_done), .sclk(ser_clk),
        .sdo(ser_data), .sel(ser_sel)
    );
endmodule

// File: rtl/dacu_chk.sv
// Checker for dac_update_ctrl, bound to every instance of the top.
module dacu_chk
    import dacu_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    localparam int unsigned NCONV = NUM_CH + 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_wr,
    input logic [7:0]       host_addr,
    input logic [15:0]      host_wdata,
    input logic [NCONV-1:0] ser_sel,
    input logic [NCONV-1:0] busy
);
    // R2: channel write makes that channel busy on the next cycle
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        a_r2_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
            (host_wr && host_addr == ADDR_CH_BASE + 8'(2 * n)) |=> busy[n]);
    end

    // R7: reference write makes the selected reference converter busy
    a_r7_ref_busy_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == ADDR_REF && host_wdata[8]) |=> busy[NUM_CH]);
    a_r7_ref_busy_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == ADDR_REF && !host_wdata[8]) |=> busy[NUM_CH+1]);

    // R3: at most one select, unchanged while held
    a_r3_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ser_sel));
    a_r3_select_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ser_sel) != '0 && ser_sel != '0) |-> ser_sel == $past(ser_sel));

    for (genvar i = 0; i < NCONV; i++) begin : g_conv
        // R4: a selected converter is busy
        a_r4_sel_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
            ser_sel[i] |-> busy[i]);
        // R4: busy only falls one cycle after the select has dropped
        a_r4_clear_after_shift: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(busy[i]) |-> ($past(ser_sel[i], 2) && !$past(ser_sel[i])));
    end
endmodule

bind dac_update_ctrl dacu_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .ser_sel(ser_sel), .busy(conv_busy)
);

// File: tb/tb_dac_update_ctrl.sv
module tb_dac_update_ctrl;
    localparam int NUM_CH = 4;
    localparam int NCONV  = NUM_CH + 2;
    localparam int DIV    = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             host_wr = 1'b0;
    logic [7:0]       host_addr = 8'h00;
    logic [15:0]      host_wdata = 16'h0000;
    logic [15:0]      host_rdata;
    logic             ser_clk;
    logic             ser_data;
    logic [NCONV-1:0] ser_sel;

    int          n_checks = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;
    logic [15:0] mon_sh = '0;
    int          mon_bits = 0;
    logic [15:0] last_word [NCONV];
    logic [15:0] prev_word [NCONV];
    int          cnt [NCONV];
    int          order_log [16];
    int          order_ptr = 0;

    dac_update_ctrl #(.NUM_CH(NUM_CH), .SCLK_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .ser_clk(ser_clk),
        .ser_data(ser_data), .ser_sel(ser_sel)
    );

    always #4 clk = ~clk;

    initial begin
        for (int i = 0; i < NCONV; i++) begin
            last_word[i] = '0; prev_word[i] = '0; cnt[i] = 0;
        end
    end

    // Serial monitor: assemble words on the rising serial clock
    always @(posedge ser_clk) begin
        int idx;
        idx = -1;
        for (int i = 0; i < NCONV; i++) if (ser_sel[i]) idx = i;
        mon_sh = {mon_sh[14:0], ser_data};
        mon_bits++;
        if (mon_bits == 16) begin
            mon_bits = 0;
            if (idx >= 0) begin
                prev_word[idx] = last_word[idx];
                last_word[idx] = mon_sh;
                cnt[idx]++;
                if (order_ptr < 16) order_log[order_ptr] = idx;
                order_ptr++;
            end
        end
    end

    function automatic logic [15:0] exp_word(int conv, logic [15:0] d, bit sgn);
        return (conv < NUM_CH && sgn) ? (d ^ 16'h8000) : d;
    endfunction

    function automatic logic [7:0] ch_addr(int n);
        return 8'h38 + 8'(2 * n);
    endfunction

    task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [15:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        for (int t = 0; t < 4000; t++) begin
            rd(8'h20, s);
            if (s[7:0] == 8'h00) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        finish_run();
    end

    initial begin
        logic [15:0] s, v;
        int c0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        rd(8'h20, s);
        check(s == 16'h0000, "R12 status", s, 16'h0000);
        rd(ch_addr(0), v);
        check(v == 16'h0000, "R12 ch0 setting", v, 16'h0000);
        check(ser_sel == '0 && !ser_clk, "R12 serial idle", {10'b0, ser_sel}, 16'h0);
        rd(8'h2C, v);
        check(v == 16'h0080, "R7 ref reset", v, 16'h0080);

        // R1 R2 R3: single channel update
        wr(ch_addr(0), 16'h1234);
        rd(8'h20, s);
        check(s[4] == 1'b1, "R2 ch0 busy next cycle", s, 16'h0010);
        wait_idle();
        check(last_word[0] == 16'h1234 && cnt[0] == 1, "R3 ch0 serial word", last_word[0], 16'h1234);
        rd(ch_addr(0), v);
        check(v == 16'h1234, "R1 ch0 readback", v, 16'h1234);

        // R1: unmapped write has no effect
        c0 = order_ptr;
        wr(8'h22, 16'h5555);
        rd(8'h20, s);
        check(s == 16'h0000, "R1 unmapped status", s, 16'h0000);
        repeat (10) @(negedge clk);
        check(order_ptr == c0, "R1 unmapped no update", 16'(order_ptr), 16'(c0));
        rd(ch_addr(1), v);
        check(v == 16'h0000, "R1 unmapped readback", v, 16'h0000);

        // R7: reference converters selected by bit 8
        wr(8'h2C, 16'h0180);
        rd(8'h20, s);
        check(s[1] == 1'b1, "R2 ref busy bit", s, 16'h0002);
        wait_idle();
        check(last_word[NUM_CH] == 16'h0180, "R7 positive ref word", last_word[NUM_CH], 16'h0180);
        wr(8'h2C, 16'h0075);
        wait_idle();
        check(last_word[NUM_CH+1] == 16'h0075, "R7 negative ref word", last_word[NUM_CH+1], 16'h0075);
        rd(8'h2C, v);
        check(v == 16'h0075, "R7 ref readback", v, 16'h0075);

        // R5: back-to-back writes to one channel
        c0 = cnt[1];
        wr(ch_addr(1), 16'hA1A1);
        wr(ch_addr(1), 16'hB2B2);
        rd(8'h20, s);
        check(s[0] == 1'b1, "R5 hold flag set", s, 16'h0001);
        wait_idle();
        check(cnt[1] == c0 + 2, "R5 two updates", 16'(cnt[1]), 16'(c0 + 2));
        check(prev_word[1] == 16'hA1A1 && last_word[1] == 16'hB2B2, "R5 order of held write",
              last_word[1], 16'hB2B2);

        // R10: discard held write
        c0 = cnt[2];
        wr(ch_addr(2), 16'hC3C3);
        wr(ch_addr(2), 16'hD4D4);
        wr(8'h20, 16'h0004);
        rd(8'h20, s);
        check(s[0] == 1'b0 && s[6] == 1'b1, "R10 hold discarded", s, 16'h0040);
        wait_idle();
        check(cnt[2] == c0 + 1 && last_word[2] == 16'hC3C3, "R10 only first update",
              last_word[2], 16'hC3C3);

        // R9: signed mode inverts channel MSB only
        wr(8'h20, 16'h0002);
        rd(8'h20, s);
        check(s[13] == 1'b1, "R9 signed flag", s, 16'h2000);
        wr(ch_addr(3), 16'h0005);
        wait_idle();
        check(last_word[3] == 16'h8005, "R9 signed channel word", last_word[3], 16'h8005);
        wr(8'h2C, 16'h0190);
        wait_idle();
        check(last_word[NUM_CH] == 16'h0190, "R9 ref unaffected", last_word[NUM_CH], 16'h0190);
        wr(8'h20, 16'h0000);
        rd(8'h20, s);
        check(s[13] == 1'b0, "R9 unsigned flag", s, 16'h0000);

        // R8: enable and disable
        wr(8'h20, 16'h0021);
        wr(8'h20, 16'h0031);
        rd(8'h20, s);
        check(s[11:8] == 4'b0011, "R8 enable ch0 ch1", s, 16'h0300);
        wr(8'h20, 16'h0020);
        rd(8'h20, s);
        check(s[11:8] == 4'b0010, "R8 disable ch0", s, 16'h0200);

        // R11: pattern flag
        wr(8'h20, 16'h0061);
        rd(8'h20, s);
        check(s[12] == 1'b1, "R11 pattern on", s, 16'h1000);
        wr(8'h20, 16'h0060);
        rd(8'h20, s);
        check(s[12] == 1'b0, "R11 pattern off", s, 16'h0000);

        // R6: arbitration order
        c0 = order_ptr;
        wr(ch_addr(3), 16'h3333);
        wr(8'h2C, 16'h0044);
        wr(ch_addr(1), 16'h1111);
        wr(ch_addr(0), 16'h0F0F);
        wait_idle();
        check(order_ptr == c0 + 4 && order_log[c0] == 3 && order_log[c0+1] == 0 &&
              order_log[c0+2] == 1 && order_log[c0+3] == NUM_CH + 1,
              "R6 service order", 16'(order_log[c0+1]), 16'h0000);

        // R3 R9 R7: random updates
        for (int k = 0; k < 30; k++) begin
            int conv;
            bit sgn;
            logic [15:0] d;
            conv = int'($urandom % NCONV);
            sgn  = 1'($urandom);
            d    = 16'($urandom);
            wr(8'h20, {14'b0, sgn, 1'b0});
            if (conv < NUM_CH) begin
                wr(ch_addr(conv), d);
            end else begin
                d[8] = (conv == NUM_CH);
                wr(8'h2C, d);
            end
            wait_idle();
            check(last_word[conv] == exp_word(conv, d, sgn), "R3 random word",
                  last_word[conv], exp_word(conv, d, sgn));
        end

        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
    end
endmodule